// File: doc/BRIEF.md
# SD Card Single-Sector Transfer Sequencer

This block moves one 512-byte sector between a memory card in SPI mode and the rest of the chip. A one-cycle `start` pulse with `wr_mode`, a 32-bit sector number and a token poll budget begins a transfer. The sequencer pulls the card select low and frames every byte itself. It hands each byte to an external byte-wide SPI shifter through a plain go/done pair. Sector data leaves through a valid/ready read stream or enters through a valid/ready write stream. When the transfer ends, a one-cycle `done` pulse is given, with a `timed_out` flag that tells a completed read from one that gave up.

Every frame starts with two fill bytes (0xFF) and then the command byte. The sector number follows as four bytes, highest byte first, and then a dummy check byte. A read then clocks out 0xFF until the card answers with the start token 0xFE, clocks in the sector and throws away two trailing check bytes. A write sends the token itself, then the sector and two dummy check bytes. Back-pressure works in both directions. A read byte stays on `rd_data` until it is taken, and the next byte is not clocked until then. During a write, no data byte goes out until the producer offers one. The SPI shifter therefore simply pauses.

Top module: `sd_sector_seq`

## Requirements
- R1: After reset `card_sel_n` is 1 and `spi_go`, `done`, `timed_out`, `rd_valid` and `wr_ready` are 0.
- R2: A `start` pulse while idle pulls `card_sel_n` low. The bytes sent are then 0xFF, 0xFF, the command (0x51 for a read with `wr_mode`=0, 0x58 for a write with `wr_mode`=1), `sector_addr` bits 31:24, 23:16, 15:8 and 7:0 in that order, and then the check byte 0xFF. `card_sel_n` is 0 whenever `spi_go` is 1.
- R3: `spi_go` is a one-cycle pulse. A new one is never given until the `spi_done` of the previous byte has been seen.
- R4: After the check byte, a read sends 0xFF until a received byte equals 0xFE. At most `poll_limit` such bytes are sent, and a limit of 0 counts as 1. If the last allowed byte is not 0xFE, the transfer ends with `timed_out`=1 and no data is presented.
- R5: After the token, a read sends 0xFF 512 times. Each received byte appears on `rd_data` with `rd_valid`=1 and stays unchanged until `rd_ready` is 1 at a clock edge. No `spi_go` is given while `rd_valid` is 1.
- R6: After the 512 data bytes, a read sends two more 0xFF bytes. The bytes received for them never appear on `rd_data`.
- R7: After the check byte, a write sends 0xFE, then 512 bytes taken from the write stream, then 0xFF, 0xFF. `wr_ready` is 1 only while the sequencer waits for a data byte. A byte taken at a clock edge is on `spi_tx` with `spi_go`=1 in the next cycle, and no data byte is sent while `wr_valid` is 0.
- R8: At the end of a transfer, `card_sel_n` returns to 1 in the same cycle as a one-cycle `done` pulse. `timed_out` keeps its value until the next accepted `start`.
- R9: A `start` pulse during a transfer is ignored, and the byte stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| wr_mode | input | 1 | 1 = write the sector, 0 = read it |
| sector_addr | input | 32 | Sector number, sampled with `start` |
| poll_limit | input | POLL_W | Most token poll bytes allowed, sampled with `start` |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| timed_out | output | 1 | Last read gave up waiting for the token |
| card_sel_n | output | 1 | Card select, active low |
| spi_go | output | 1 | Pulse: shift out `spi_tx` |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Pulse: shift finished, `spi_rx` valid |
| spi_rx | input | 8 | Byte received during the shift |
| rd_data | output | 8 | Read stream data |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| wr_data | input | 8 | Write stream data |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |

## Verification
The hardest situations to reach are those where back-pressure lands exactly on a byte boundary. One is a read byte that the consumer refuses for many cycles while the shifter sits idle. The other is a write producer that drops `wr_valid` right after a hand-over, while that byte is still shifting. The bench reaches both by counting hand-overs and opening a 40-cycle stall window at a chosen byte index. Inside the window it checks that no byte is issued, that the held read byte stays still and that `wr_ready` is waiting at the end. The token poll is driven by a scripted card response. It places 0xFE on the first byte, on the last allowed byte, or nowhere, with `poll_limit` values of 0, 4, 5 and 10.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SYNC,
    PH_CMD,
    PH_ADDR,
    PH_CHK,
    PH_POLL,
    PH_RDATA,
    PH_RTAIL,
    PH_WTOK,
    PH_WDATA,
    PH_WTAIL
  } phase_t;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] TOKEN_BYTE = 8'hFE;
  localparam int         ADDR_BYTES = 4;

endpackage

// File: rtl/sd_tx_select.sv
module sd_tx_select
  import sd_seq_pkg::*;
#(
  parameter logic [7:0] RD_CMD   = 8'h51,
  parameter logic [7:0] WR_CMD   = 8'h58,
  parameter logic [7:0] CHK_BYTE = 8'hFF
) (
  input  phase_t      phase,
  input  logic [1:0]  addr_pos,
  input  logic        wr_mode,
  input  logic [31:0] addr,
  input  logic [7:0]  wr_data,
  output logic [7:0]  tx
);

  // position 0 carries the most significant address byte
  logic [1:0] lane;
  assign lane = 2'd3 - addr_pos;

  always_comb begin
    case (phase)
      PH_CMD:   tx = wr_mode ? WR_CMD : RD_CMD;
      PH_ADDR:  tx = addr[{lane, 3'b000} +: 8];
      PH_CHK:   tx = CHK_BYTE;
      PH_WTOK:  tx = TOKEN_BYTE;
      PH_WDATA: tx = wr_data;
      default:  tx = FILL_BYTE;
    endcase
  end

endmodule

// File: rtl/sd_poll_timer.sv
module sd_poll_timer #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [POLL_W-1:0] limit,
  output logic              last_poll
);

  logic [POLL_W-1:0] polls_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     polls_seen <= '0;
    else if (clear) polls_seen <= '0;
    else if (step)  polls_seen <= polls_seen + 1'b1;
  end

  // the byte now completing is the last one the budget allows (0 acts as 1)
  assign last_poll = ({1'b0, polls_seen} + {{POLL_W{1'b0}}, 1'b1}) >= {1'b0, limit};

endmodule

// File: rtl/sd_phase_fsm.sv
module sd_phase_fsm
  import sd_seq_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SYNC_BYTES   = 2,
  parameter int TAIL_BYTES   = 2,
  parameter int IDX_W        = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_mode_in,
  input  logic             fin,
  input  logic [7:0]       rx_byte,
  input  logic             last_poll,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic             wr_mode,
  output logic             done,
  output logic             timed_out,
  output logic             poll_clear,
  output logic             poll_step
);

  localparam logic [IDX_W-1:0] SEC_LAST  = IDX_W'(SECTOR_BYTES - 1);
  localparam logic [IDX_W-1:0] SYNC_LAST = IDX_W'(SYNC_BYTES - 1);
  localparam logic [IDX_W-1:0] TAIL_LAST = IDX_W'(TAIL_BYTES - 1);
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_BYTES - 1);

  logic [IDX_W-1:0] last_idx;
  logic             got_token;
  logic             give_up;
  logic             launch;
  phase_t           nxt;

  assign got_token  = (rx_byte == TOKEN_BYTE);
  assign give_up    = (phase == PH_POLL) && !got_token && last_poll;
  assign launch     = (phase == PH_IDLE) && start;
  assign poll_clear = (phase == PH_IDLE);
  assign poll_step  = fin && (phase == PH_POLL) && !got_token;

  always_comb begin
    case (phase)
      PH_SYNC:             last_idx = SYNC_LAST;
      PH_ADDR:             last_idx = ADDR_LAST;
      PH_RDATA, PH_WDATA:  last_idx = SEC_LAST;
      PH_RTAIL, PH_WTAIL:  last_idx = TAIL_LAST;
      default:             last_idx = '0;
    endcase
  end

  always_comb begin
    case (phase)
      PH_SYNC:  nxt = PH_CMD;
      PH_CMD:   nxt = PH_ADDR;
      PH_ADDR:  nxt = PH_CHK;
      PH_CHK:   nxt = wr_mode ? PH_WTOK : PH_POLL;
      PH_POLL:  nxt = got_token ? PH_RDATA : (last_poll ? PH_IDLE : PH_POLL);
      PH_RDATA: nxt = PH_RTAIL;
      PH_WTOK:  nxt = PH_WDATA;
      PH_WDATA: nxt = PH_WTAIL;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      wr_mode   <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        phase     <= PH_SYNC;
        idx       <= '0;
        wr_mode   <= wr_mode_in;
        timed_out <= 1'b0;
      end else if (fin && (phase != PH_IDLE)) begin
        if (idx == last_idx) begin
          phase <= nxt;
          idx   <= '0;
          if (nxt == PH_IDLE) done <= 1'b1;
          if (give_up) timed_out <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sd_sector_seq.sv
module sd_sector_seq
  import sd_seq_pkg::*;
#(
  parameter int         SECTOR_BYTES = 512,
  parameter int         SYNC_BYTES   = 2,
  parameter int         TAIL_BYTES   = 2,
  parameter int         POLL_W       = 16,
  parameter logic [7:0] RD_CMD       = 8'h51,
  parameter logic [7:0] WR_CMD       = 8'h58,
  parameter logic [7:0] CHK_BYTE     = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_mode,
  input  logic [31:0]       sector_addr,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              done,
  output logic              timed_out,
  output logic              card_sel_n,
  output logic              spi_go,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready
);

  localparam int IDX_W = $clog2(SECTOR_BYTES);

  phase_t            phase;
  logic [IDX_W-1:0]  idx;
  logic              mode_q;
  logic [31:0]       addr_q;
  logic [POLL_W-1:0] limit_q;
  logic              inflight;
  logic              fin;
  logic              can_send;
  logic              last_poll;
  logic              poll_clear;
  logic              poll_step;
  logic [7:0]        tx_next;
  logic              in_rdata;
  logic              in_wdata;

  assign in_rdata   = (phase == PH_RDATA);
  assign in_wdata   = (phase == PH_WDATA);
  assign card_sel_n = (phase == PH_IDLE);

  // a read data byte is finished when the consumer takes it, others when shifted
  assign fin = in_rdata ? (rd_valid && rd_ready) : spi_done;

  assign wr_ready = in_wdata && !inflight;
  assign can_send = (phase != PH_IDLE) && !inflight
                    && !(in_rdata && rd_valid)
                    && !(in_wdata && !wr_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      limit_q <= '0;
    end else if ((phase == PH_IDLE) && start) begin
      addr_q  <= sector_addr;
      limit_q <= poll_limit;
    end
  end

  sd_phase_fsm #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .SYNC_BYTES   (SYNC_BYTES),
    .TAIL_BYTES   (TAIL_BYTES),
    .IDX_W        (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wr_mode_in (wr_mode),
    .fin        (fin),
    .rx_byte    (spi_rx),
    .last_poll  (last_poll),
    .phase      (phase),
    .idx        (idx),
    .wr_mode    (mode_q),
    .done       (done),
    .timed_out  (timed_out),
    .poll_clear (poll_clear),
    .poll_step  (poll_step)
  );

  sd_poll_timer #(.POLL_W(POLL_W)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (poll_clear),
    .step      (poll_step),
    .limit     (limit_q),
    .last_poll (last_poll)
  );

  sd_tx_select #(
    .RD_CMD   (RD_CMD),
    .WR_CMD   (WR_CMD),
    .CHK_BYTE (CHK_BYTE)
  ) u_txsel (
    .phase    (phase),
    .addr_pos (idx[1:0]),
    .wr_mode  (mode_q),
    .addr     (addr_q),
    .wr_data  (wr_data),
    .tx       (tx_next)
  );

  // byte issue: one byte on the wire at a time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_go   <= 1'b0;
      spi_tx   <= FILL_BYTE;
      inflight <= 1'b0;
    end else begin
      spi_go <= 1'b0;
      if (can_send) begin
        spi_go   <= 1'b1;
        spi_tx   <= tx_next;
        inflight <= 1'b1;
      end else if (spi_done) begin
        inflight <= 1'b0;
      end
    end
  end

  // read hold register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (spi_done && in_rdata) begin
      rd_valid <= 1'b1;
      rd_data  <= spi_rx;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sd_sector_seq_chk.sv
module sd_sector_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_go,
  input logic [7:0] spi_tx,
  input logic       card_sel_n,
  input logic       done,
  input logic       timed_out,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] wr_data,
  input logic       wr_valid,
  input logic       wr_ready
);

  // R2
  go_sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> !card_sel_n);

  // R3
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |=> !spi_go);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R5
  no_issue_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_go);

  // R7
  wr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (spi_go && spi_tx == $past(wr_data)));

  // R8
  done_sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> card_sel_n);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  timeout_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> !rd_valid);

endmodule

bind sd_sector_seq sd_sector_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_go     (spi_go),
  .spi_tx     (spi_tx),
  .card_sel_n (card_sel_n),
  .done       (done),
  .timed_out  (timed_out),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .wr_data    (wr_data),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready)
);

// File: tb/sd_sector_seq_bench.sv
`timescale 1ns/1ps
module sd_sector_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        wr_mode;
  logic [31:0] sector_addr;
  logic [15:0] poll_limit;
  logic        done, timed_out, card_sel_n, spi_go;
  logic [7:0]  spi_tx;
  logic        spi_done;
  logic [7:0]  spi_rx;
  logic [7:0]  rd_data;
  logic        rd_valid, rd_ready;
  logic [7:0]  wr_data;
  logic        wr_valid, wr_ready;

  always #2 clk = ~clk;

  sd_sector_seq u_sd_sector_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode),
    .sector_addr(sector_addr), .poll_limit(poll_limit), .done(done),
    .timed_out(timed_out), .card_sel_n(card_sel_n), .spi_go(spi_go),
    .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;

  // reference model state
  logic [7:0] exp_tx[$];
  string      exp_tag[$];
  logic [7:0] rx_q[$];
  logic [7:0] exp_rd[$];
  int         lat = 2, lat_cnt = 0;
  logic [7:0] pending = 8'hFF;
  int         rd_cnt = 0, rd_hold_at = 0, rd_hold_left = 0;
  logic [7:0] rd_held = 8'h00;
  bit         held_ok = 0;
  int         hold_viol = 0, issue_viol = 0;
  bit         wr_active = 0;
  int         widx = 0, wr_hold_at = 0, wr_hold_left = 0, wr_hold_go = 0;
  bit         wr_ready_at_end = 0;
  logic [7:0] e_byte;
  string      e_tag;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wpat(input int i);
    return 8'(i * 13 + 60);
  endfunction

  function automatic logic [7:0] rpat(input int i, input int seed);
    return 8'(i * 29 + seed);
  endfunction

  // card, consumer and producer model, compared every clock
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      spi_done = 1'b0;
      if (spi_go) begin
        check(lat_cnt == 0, "R3 one byte in flight", lat_cnt, 0);
        check(!card_sel_n, "R2 select low while shifting", card_sel_n, 0);
        if (rd_valid) issue_viol++;
        if (wr_hold_left > 0 && wr_hold_left < 40) wr_hold_go++;
        if (exp_tx.size() == 0) begin
          check(1'b0, "R9 unexpected byte issued", spi_tx, 0);
        end else begin
          e_tag  = exp_tag.pop_front();
          e_byte = exp_tx.pop_front();
          check(spi_tx == e_byte, e_tag, spi_tx, e_byte);
        end
        pending = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
        lat_cnt = lat;
      end else if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          spi_done = 1'b1;
          spi_rx   = pending;
        end
      end

      // read consumer
      if (rd_hold_left > 0) begin
        rd_ready = 1'b0;
        if (rd_valid) begin
          if (held_ok && rd_data !== rd_held) hold_viol++;
          rd_held = rd_data;
          held_ok = 1;
        end else begin
          held_ok = 0;
        end
        rd_hold_left--;
      end else begin
        rd_ready = (cyc % 3) != 1;
      end
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) begin
          check(1'b0, "R6 surplus read byte", rd_data, 0);
        end else begin
          e_byte = exp_rd.pop_front();
          check(rd_data == e_byte, "R5 read data", rd_data, e_byte);
        end
        rd_cnt++;
        if (rd_cnt == rd_hold_at) begin
          rd_hold_left = 40;
          held_ok = 0;
        end
      end

      // write producer
      if (wr_active) begin
        if (wr_hold_left > 0) begin
          wr_valid = 1'b0;
          if (wr_hold_left == 1) wr_ready_at_end = wr_ready;
          wr_hold_left--;
        end else begin
          wr_valid = (widx < 512) && ((cyc % 4) != 2);
          wr_data  = wpat(widx);
        end
        if (wr_valid && wr_ready) begin
          widx++;
          if (widx == wr_hold_at) wr_hold_left = 40;
        end
      end else begin
        wr_valid = 1'b0;
      end
    end
  end

  task automatic push_tx(input logic [7:0] b, input string tag);
    exp_tx.push_back(b);
    exp_tag.push_back(tag);
  endtask

  task automatic push_hdr(input logic [7:0] cmd, input logic [31:0] addr);
    push_tx(8'hFF, "R2 sync byte");
    push_tx(8'hFF, "R2 sync byte");
    push_tx(cmd, "R2 command byte");
    push_tx(addr[31:24], "R2 address byte 3");
    push_tx(addr[23:16], "R2 address byte 2");
    push_tx(addr[15:8],  "R2 address byte 1");
    push_tx(addr[7:0],   "R2 address byte 0");
    push_tx(8'hFF, "R2 check byte");
    for (int i = 0; i < 8; i++) rx_q.push_back(8'hFF);
  endtask

  task automatic kick(input bit wm, input logic [31:0] addr, input int limit);
    @(negedge clk);
    start = 1'b1; wr_mode = wm; sector_addr = addr; poll_limit = 16'(limit);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input bit exp_to, input string tag);
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(done, {tag, " R8 done seen"}, done, 1);
    check(card_sel_n, "R8 select high at done", card_sel_n, 1);
    check(timed_out == exp_to, "R8 timeout flag", timed_out, exp_to);
    @(negedge clk);
    check(!done, "R8 done is one cycle", done, 0);
    repeat (6) @(negedge clk);
    check(timed_out == exp_to, "R8 flag held until next start", timed_out, exp_to);
    check(card_sel_n, "R8 select stays high", card_sel_n, 1);
  endtask

  task automatic run_read(input logic [31:0] addr, input int limit, input int fe_at,
                          input int hold_at, input int l, input int seed, input bit stray);
    int polls;
    bit ok;
    ok    = fe_at > 0;
    polls = ok ? fe_at : ((limit < 1) ? 1 : limit);
    lat = l; rd_cnt = 0; rd_hold_at = hold_at; rd_hold_left = 0;
    issue_viol = 0; hold_viol = 0; wr_active = 0;
    push_hdr(8'h51, addr);
    for (int i = 0; i < polls; i++) begin
      push_tx(8'hFF, "R4 poll byte");
      rx_q.push_back((ok && i == polls - 1) ? 8'hFE : 8'hFF);
    end
    if (ok) begin
      for (int i = 0; i < 512; i++) begin
        push_tx(8'hFF, "R5 data clock byte");
        rx_q.push_back(rpat(i, seed));
        exp_rd.push_back(rpat(i, seed));
      end
      push_tx(8'hFF, "R6 tail byte");
      push_tx(8'hFF, "R6 tail byte");
      rx_q.push_back(8'hFE);
      rx_q.push_back(8'h00);
    end
    kick(1'b0, addr, limit);
    if (stray) begin
      repeat (20) @(negedge clk);
      start = 1'b1; wr_mode = 1'b1; sector_addr = ~addr; poll_limit = 16'd1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(!ok, ok ? "read" : "read timeout");
    check(rd_cnt == (ok ? 512 : 0), ok ? "R5 bytes delivered" : "R4 no data after timeout", rd_cnt, ok ? 512 : 0);
    check(exp_rd.size() == 0, "R5 all read data delivered", exp_rd.size(), 0);
    check(exp_tx.size() == 0, stray ? "R9 stray start ignored" : "R4 byte count", exp_tx.size(), 0);
    check(rx_q.size() == 0, "R4 poll stopped at token or limit", rx_q.size(), 0);
    check(issue_viol == 0, "R5 no byte issued while data held", issue_viol, 0);
    check(hold_viol == 0, "R5 held byte stable", hold_viol, 0);
    exp_rd.delete(); exp_tx.delete(); exp_tag.delete(); rx_q.delete();
  endtask

  task automatic run_write(input logic [31:0] addr, input int hold_at, input int l);
    lat = l; widx = 0; wr_hold_at = hold_at; wr_hold_left = 0;
    wr_hold_go = 0; wr_ready_at_end = 0; rd_hold_at = 0; issue_viol = 0;
    push_hdr(8'h58, addr);
    push_tx(8'hFE, "R7 start token");
    for (int i = 0; i < 512; i++) push_tx(wpat(i), "R7 data byte");
    push_tx(8'hFF, "R7 tail byte");
    push_tx(8'hFF, "R7 tail byte");
    rx_q.delete();
    wr_active = 1;
    kick(1'b1, addr, 3);
    wait_done(1'b0, "write");
    wr_active = 0;
    check(widx == 512, "R7 bytes taken from stream", widx, 512);
    check(exp_tx.size() == 0, "R7 full frame sent", exp_tx.size(), 0);
    if (hold_at > 0) begin
      check(wr_hold_go == 0, "R7 nothing sent while producer idle", wr_hold_go, 0);
      check(wr_ready_at_end == 1, "R7 ready while waiting for data", wr_ready_at_end, 1);
    end
    exp_tx.delete(); exp_tag.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_mode = 1'b0; sector_addr = '0; poll_limit = '0;
    spi_done = 1'b0; spi_rx = 8'h00; rd_ready = 1'b0; wr_valid = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    check(card_sel_n == 1, "R1 select idle high", card_sel_n, 1);
    check(spi_go == 0,     "R1 no go in reset", spi_go, 0);
    check(done == 0,       "R1 done low", done, 0);
    check(timed_out == 0,  "R1 timeout low", timed_out, 0);
    check(rd_valid == 0,   "R1 read valid low", rd_valid, 0);
    check(wr_ready == 0,   "R1 write ready low", wr_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(spi_go == 0 && card_sel_n == 1, "R1 quiet after reset", spi_go, 0);

    run_read(32'h1234_5678, 10, 3, 100, 2, 7, 1'b1);  // stall and stray start
    run_write(32'hA500_0001, 200, 1);                  // producer stall
    run_read(32'h0000_0042, 4, 0, 0, 3, 0, 1'b0);      // R4 timeout after 4 polls
    run_read(32'hFFFF_0000, 5, 5, 0, 1, 91, 1'b0);     // token on last allowed poll
    run_read(32'h8000_0000, 0, 1, 511, 2, 3, 1'b0);    // limit 0 acts as 1, token at once
    run_read(32'h0102_0304, 0, 0, 0, 1, 0, 1'b0);      // limit 0, no token: one poll
    run_write(32'h0000_00FF, 0, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule